// File: doc/BRIEF.md
# Receive Byte Queue with Hardware RTS Throttling

This block is the 32-entry receive queue that sits between a UART deserialiser and the host. Each received byte arrives with a write strobe, and the host removes bytes with a read strobe. The oldest byte is always visible on the read data port. Two trigger-select bits and a table-select input choose a fill threshold. When the fill reaches that threshold, the block raises a data-ready interrupt.

The same threshold also drives flow control. With automatic throttling enabled, the queue pushes the RTS pin to its high (stop) level as soon as the fill reaches the threshold, whatever level software has programmed. The pin goes back to the software level only when the fill drops under the next smaller threshold of the active table. This gives the sender hysteresis instead of a flag that toggles on every byte. While the pin is held high, the queue still accepts bytes into its free entries. A byte that arrives when the queue is full is dropped, and a sticky overrun flag records the loss.

The throttle controller is a three-state machine:
- `FLOW_BYPASS` is the reset state. The block is in this state whenever throttling is disabled, and the pin follows software.
- `FLOW_OPEN`: throttling is enabled, the pin follows software and the fill is watched.
- `FLOW_HELD`: the pin is forced high.

Transitions:
- BYPASS→OPEN: enable, with the new fill under the threshold.
- BYPASS→HELD: enable, with the new fill at or above the threshold.
- OPEN→HELD: the new fill reaches the threshold.
- HELD→OPEN: the new fill is under the release limit.
- Any state→BYPASS: enable goes low.

Top module: `uart_rxq_autorts`

## Requirements
- R1: With `enh_mode`=1, `trig_sel` codes 0,1,2,3 select thresholds of 8,16,24,28 bytes. `trig_irq` is 1 exactly when `fill_count` is at or above the selected threshold, and it reflects the fill in the cycle after each write or read.
- R2: With `enh_mode`=0, `trig_sel` codes 0,1,2,3 select thresholds of 1,4,8,14 bytes, with the same interrupt rule as R1.
- R3: With `auto_rts_en`=1, `rts_pin` is 1 from the cycle the fill reaches the selected threshold, regardless of `sw_rts_lvl`. This also holds when throttling is enabled while the fill is already at or above the threshold; the pin goes high after the next clock edge.
- R4: Once forced, `rts_pin` stays 1 until the fill falls under the release limit. The release limit is the next smaller threshold of the active table. For code 0 the release limit is an empty queue (fill 0). After release, the pin returns to `sw_rts_lvl`.
- R5: While `rts_pin` is forced, writes are still stored until the fill reaches 32.
- R6: Bytes are read out in arrival order. `rd_data` shows the oldest stored byte, and a read advances to the next one.
- R7: A write arriving while the queue holds 32 bytes is discarded and sets `overrun`. This also applies when a read occurs in the same cycle: the read is performed and the write is dropped. `overrun` stays set until a cycle with `ovr_ack`=1 and no new overrun; a new overrun in the same cycle as `ovr_ack` wins.
- R8: With `auto_rts_en`=0, `rts_pin` equals `sw_rts_lvl` in the same cycle.
- R9: A write and a read in the same cycle, with the queue neither empty nor full, leave `fill_count` unchanged. A read of an empty queue is ignored; if it comes with a write, only the write takes effect.
- R10: While and after reset, `fill_count`, `trig_irq` and `overrun` are 0, and `rts_pin` follows `sw_rts_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe |
| trig_sel | input | 2 | Threshold code |
| enh_mode | input | 1 | 1 = enhanced table, 0 = compatibility table |
| auto_rts_en | input | 1 | Enables hardware RTS throttling |
| sw_rts_lvl | input | 1 | Software-programmed RTS pin level |
| ovr_ack | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest stored byte |
| fill_count | output | 6 | Number of stored bytes (0..32) |
| trig_irq | output | 1 | Data-ready interrupt |
| overrun | output | 1 | Sticky dropped-byte flag |
| rts_pin | output | 1 | RTS pin level, 1 = stop |

## Verification
The RTS properties assume that `trig_sel`, `enh_mode` and `auto_rts_en` have been stable since the previous clock edge. A table switch is only evaluated at the next edge, so the properties are qualified with that stability. The bench therefore changes the configuration only under reset or between idle cycles, and it sweeps all eight table/code combinations through a full fill and a full drain. Strobes are one cycle wide and driven on the falling edge. The flag properties assume that `ovr_ack` is a pulse; the bench also drives it together with a write into a full queue to exercise set priority.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef enum logic [1:0] {
        FLOW_BYPASS = 2'd0,
        FLOW_OPEN   = 2'd1,
        FLOW_HELD   = 2'd2
    } flow_state_e;

    // Enhanced threshold table, in bytes
    function automatic int enh_level(input logic [1:0] code);
        int lvl;
        unique case (code)
            2'd0:    lvl = 8;
            2'd1:    lvl = 16;
            2'd2:    lvl = 24;
            default: lvl = 28;
        endcase
        return lvl;
    endfunction

    // Compatibility threshold table, in bytes
    function automatic int cmp_level(input logic [1:0] code);
        int lvl;
        unique case (code)
            2'd0:    lvl = 1;
            2'd1:    lvl = 4;
            2'd2:    lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 32,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              pop_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  count_next_o,
    output logic              overrun_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              ovr_q;
    logic              is_full;
    logic              is_empty;
    logic              do_push;
    logic              do_pop;

    assign is_full  = (count_q == FULL_CNT);
    assign is_empty = (count_q == '0);
    assign do_push  = push_i && !is_full;
    assign do_pop   = pop_i && !is_empty;

    always_comb begin
        count_next_o = count_q;
        unique case ({do_push, do_pop})
            2'b10:   count_next_o = count_q + CNT_W'(1);
            2'b01:   count_next_o = count_q - CNT_W'(1);
            default: count_next_o = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            count_q <= count_next_o;
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr_q] <= din_i;
        end
    end

    // Overrun: a dropped byte takes priority over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (push_i && is_full) begin
            ovr_q <= 1'b1;
        end else if (ack_i) begin
            ovr_q <= 1'b0;
        end
    end

    assign dout_o    = mem[rd_ptr_q];
    assign count_o   = count_q;
    assign overrun_o = ovr_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && is_full) |=> (count_q == FULL_CNT) && ovr_q); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ack_i) |=> ovr_q); // R7
    AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !is_full && !is_empty) |=> $stable(count_q)); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && is_empty) |=> (count_q == '0)); // R9

endmodule

// File: rtl/rxq_thresh.sv
`timescale 1ns/1ps
module rxq_thresh
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             enh_i,
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] trig_o,
    output logic [CNT_W-1:0] rel_o
);

    int         trig_raw;
    int         rel_raw;
    logic [1:0] lower_sel;

    assign lower_sel = sel_i - 2'd1;

    always_comb begin
        trig_raw = enh_i ? enh_level(sel_i) : cmp_level(sel_i);
        // Release limit: fill must drop under this value; code 0 releases on empty
        if (sel_i == 2'd0) begin
            rel_raw = 1;
        end else begin
            rel_raw = enh_i ? enh_level(lower_sel) : cmp_level(lower_sel);
        end
        trig_o = CNT_W'((trig_raw > DEPTH) ? DEPTH : trig_raw);
        rel_o  = CNT_W'((rel_raw  > DEPTH) ? DEPTH : rel_raw);
    end

endmodule

// File: rtl/rxq_rts_fsm.sv
`timescale 1ns/1ps
module rxq_rts_fsm
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en_i,
    input  logic             sw_lvl_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] trig_i,
    input  logic [CNT_W-1:0] rel_i,
    output logic             rts_o
);

    flow_state_e state_q;
    flow_state_e state_d;
    logic        at_trig;
    logic        under_rel;

    assign at_trig   = (cnt_next_i >= trig_i);
    assign under_rel = (cnt_next_i < rel_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLOW_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic, evaluated on the fill the coming edge will hold
    always_comb begin
        state_d = state_q;
        if (!auto_en_i) begin
            state_d = FLOW_BYPASS;
        end else begin
            unique case (state_q)
                FLOW_BYPASS: state_d = at_trig ? FLOW_HELD : FLOW_OPEN;
                FLOW_OPEN:   state_d = at_trig ? FLOW_HELD : FLOW_OPEN;
                FLOW_HELD:   state_d = under_rel ? FLOW_OPEN : FLOW_HELD;
                default:     state_d = FLOW_BYPASS;
            endcase
        end
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            FLOW_HELD: rts_o = auto_en_i ? 1'b1 : sw_lvl_i;
            default:   rts_o = sw_lvl_i;
        endcase
    end

endmodule

// File: rtl/uart_rxq_autorts.sv
`timescale 1ns/1ps
module uart_rxq_autorts #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 32,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        trig_sel,
    input  logic              enh_mode,
    input  logic              auto_rts_en,
    input  logic              sw_rts_lvl,
    input  logic              ovr_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_count,
    output logic              trig_irq,
    output logic              overrun,
    output logic              rts_pin
);

    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] trig_lvl;
    logic [CNT_W-1:0] rel_lvl;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (wr_en),
        .din_i        (wr_data),
        .pop_i        (rd_en),
        .ack_i        (ovr_ack),
        .dout_o       (rd_data),
        .count_o      (fill_count),
        .count_next_o (cnt_next),
        .overrun_o    (overrun)
    );

    rxq_thresh #(.DEPTH(DEPTH)) thresh_i (
        .enh_i  (enh_mode),
        .sel_i  (trig_sel),
        .trig_o (trig_lvl),
        .rel_o  (rel_lvl)
    );

    rxq_rts_fsm #(.DEPTH(DEPTH)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en_i  (auto_rts_en),
        .sw_lvl_i   (sw_rts_lvl),
        .cnt_next_i (cnt_next),
        .trig_i     (trig_lvl),
        .rel_i      (rel_lvl),
        .rts_o      (rts_pin)
    );

    assign trig_irq = (fill_count >= trig_lvl);

    AST_RTS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && $past(auto_rts_en) && $stable(trig_sel) && $stable(enh_mode)
         && (fill_count >= trig_lvl)) |-> rts_pin); // R3
    AST_RTS_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && $past(auto_rts_en) && $stable(trig_sel) && $stable(enh_mode)
         && $past(rts_pin) && !$past(sw_rts_lvl) && (fill_count >= rel_lvl)) |-> rts_pin); // R4
    AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |-> (rts_pin == sw_rts_lvl)); // R8

endmodule

// File: tb/uart_rxq_autorts_tb_top.sv
`timescale 1ns/1ps
module uart_rxq_autorts_tb_top;

    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en, enh_mode, auto_rts_en, sw_rts_lvl, ovr_ack;
    logic [7:0] wr_data, rd_data;
    logic [1:0] trig_sel;
    logic [5:0] fill_count;
    logic       trig_irq, overrun, rts_pin;

    int checks = 0;
    int errors = 0;
    logic [7:0] q[$];

    always #2.5 clk = ~clk;

    uart_rxq_autorts #(.DATA_W(8), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .trig_sel(trig_sel), .enh_mode(enh_mode), .auto_rts_en(auto_rts_en),
        .sw_rts_lvl(sw_rts_lvl), .ovr_ack(ovr_ack), .rd_data(rd_data),
        .fill_count(fill_count), .trig_irq(trig_irq), .overrun(overrun), .rts_pin(rts_pin)
    );

    function automatic int exp_trig(input bit enh, input int code);
        if (enh) return (code == 3) ? 28 : 8 * (code + 1);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int exp_rel(input bit enh, input int code);
        return (code == 0) ? 1 : exp_trig(enh, code - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit w, input logic [7:0] d, input bit r, input bit a);
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; ovr_ack = a;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; ovr_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        repeat (2) @(negedge clk);
        chk("R10 count", 32'(fill_count), 0);
        chk("R10 irq", 32'(trig_irq), 0);
        chk("R10 overrun", 32'(overrun), 0);
        chk("R10 rts", 32'(rts_pin), 32'(sw_rts_lvl));
        rst_n = 1'b1;
    endtask

    task automatic run_cfg(input int cfg);
        bit enh;
        int code, trig, rel;
        bit held;
        logic [7:0] d;
        enh  = cfg[2];
        code = cfg & 3;
        enh_mode = enh; trig_sel = 2'(code); auto_rts_en = 1'b1; sw_rts_lvl = 1'b0;
        trig = exp_trig(enh, code);
        rel  = exp_rel(enh, code);
        do_reset();
        // Fill: R1/R2 interrupt, R3 forcing, R5 acceptance while held
        for (int i = 1; i <= DEPTH; i++) begin
            d = 8'((cfg * 37 + i * 5) & 255);
            step(1'b1, d, 1'b0, 1'b0);
            q.push_back(d);
            chk("R5 count on fill", 32'(fill_count), 32'(i));
            chk(enh ? "R1 irq" : "R2 irq", 32'(trig_irq), 32'(i >= trig));
            chk("R3 rts on fill", 32'(rts_pin), 32'(i >= trig));
        end
        // R7 drop on full, sticky flag, acknowledge
        step(1'b1, 8'hEE, 1'b0, 1'b0);
        chk("R7 count full", 32'(fill_count), 32'(DEPTH));
        chk("R7 overrun set", 32'(overrun), 1);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R7 overrun sticky", 32'(overrun), 1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R7 overrun ack", 32'(overrun), 0);
        step(1'b1, 8'hDD, 1'b0, 1'b1);
        chk("R7 set wins over ack", 32'(overrun), 1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R7 overrun ack2", 32'(overrun), 0);
        // Drain: R6 ordering, R4 hysteresis
        held = 1'b1;
        for (int n = DEPTH - 1; n >= 0; n--) begin
            chk("R6 head data", 32'(rd_data), 32'(q.pop_front()));
            step(1'b0, 8'h00, 1'b1, 1'b0);
            held = held && (n >= rel);
            chk("R6 count on drain", 32'(fill_count), 32'(n));
            chk(enh ? "R1 irq drain" : "R2 irq drain", 32'(trig_irq), 32'(n >= trig));
            chk("R4 rts hysteresis", 32'(rts_pin), 32'(held));
        end
        sw_rts_lvl = 1'b1;
        #1;
        chk("R4 follows sw after release", 32'(rts_pin), 1);
        sw_rts_lvl = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ovr_ack = 1'b0; wr_data = '0;
        trig_sel = '0; enh_mode = 1'b1; auto_rts_en = 1'b1; sw_rts_lvl = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 rts sw=1 in reset", 32'(rts_pin), 1);
        sw_rts_lvl = 1'b0;
        #1;
        chk("R10 rts sw=0 in reset", 32'(rts_pin), 0);

        for (int cfg = 0; cfg < 8; cfg++) run_cfg(cfg);

        // R8 / R3: throttling off, then enabled with fill above threshold
        enh_mode = 1'b1; trig_sel = 2'd0; auto_rts_en = 1'b0; sw_rts_lvl = 1'b0;
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        chk("R8 rts follows sw=0", 32'(rts_pin), 0);
        sw_rts_lvl = 1'b1; #1;
        chk("R8 rts follows sw=1", 32'(rts_pin), 1);
        sw_rts_lvl = 1'b0; #1;
        chk("R8 rts back to 0", 32'(rts_pin), 0);
        @(negedge clk); auto_rts_en = 1'b1;
        @(negedge clk);
        chk("R3 forced after enable", 32'(rts_pin), 1);
        sw_rts_lvl = 1'b1; #1; sw_rts_lvl = 1'b0; #1;
        chk("R3 sw ignored while held", 32'(rts_pin), 1);
        auto_rts_en = 1'b0; #1;
        chk("R8 disable releases", 32'(rts_pin), 0);

        // R9 simultaneous write and read
        auto_rts_en = 1'b1;
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 8'(10 + i), 1'b0, 1'b0);
        step(1'b1, 8'd99, 1'b1, 1'b0);
        chk("R9 count unchanged", 32'(fill_count), 5);
        chk("R6 head after simul", 32'(rd_data), 11);
        for (int i = 0; i < 5; i++) begin
            chk("R6 order after simul", 32'(rd_data), (i < 4) ? 32'(11 + i) : 32'd99);
            step(1'b0, 8'h00, 1'b1, 1'b0);
        end
        chk("R9 drained", 32'(fill_count), 0);

        // R9 empty read
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9 empty pop ignored", 32'(fill_count), 0);
        step(1'b1, 8'd55, 1'b1, 1'b0);
        chk("R9 write with empty pop", 32'(fill_count), 1);
        chk("R9 data kept", 32'(rd_data), 55);

        // R7 write and read on full queue
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        step(1'b1, 8'd77, 1'b1, 1'b0);
        chk("R7 full push+pop count", 32'(fill_count), 31);
        chk("R7 full push+pop overrun", 32'(overrun), 1);
        chk("R7 head after full pop", 32'(rd_data), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule